// File: doc/BRIEF.md
# Byte-Wide Configuration Serializer

This block takes configuration bytes from a host bus and sends each one out on a single serial data line, most significant bit first. It clocks the bits with a short train of eight configuration clock pulses per byte. The same clock line is driven out of the block, so downstream serial devices can be clocked from it directly.

By default an internal timer sets the pulse rate. Each half period of the configuration clock lasts `HALF_CYC` system clock cycles. When the `sync_mode` input is high, the internal timer is not used. Instead, an external clock is synchronised into the system clock domain, and each of its edges moves the configuration clock and the shift forward. `sync_mode` must stay stable while a byte is in flight.

The host side is a valid/ready stream:
- A byte is accepted in the cycle where `in_valid` and `in_ready` are both high.
- `in_ready` is the inverse of `busy`.
- A valid that is presented while ready is low is not latched and not queued. The host must hold `in_valid` until ready returns, or the byte is dropped.
- The `busy` status pin is a plain level for hosts that poll instead of using the handshake.

Top module: `cfg_byte_serializer`

## Requirements
- R1: After reset, `busy`=0, `in_ready`=1, `cfg_clk`=0 and `cfg_dout`=0.
- R2: A byte is accepted only when `in_valid`=1 and `in_ready`=1 at a clock edge. From the next cycle, `busy`=1 and `in_ready`=0. `busy` never rises without an accepted write.
- R3: Each accepted byte produces exactly eight rising edges on `cfg_clk`.
- R4: Bits leave MSB first. The value of `cfg_dout` at the k-th rising `cfg_clk` (k=0..7) is bit 7-k of the byte.
- R5: `cfg_dout` changes only in the cycle where `cfg_clk` falls, or in the cycle after an accepted write. It is stable on every rising edge.
- R6: In timer mode (`sync_mode`=0), every high and low phase of `cfg_clk` lasts `HALF_CYC` cycles. `busy` is therefore high for 16*`HALF_CYC` cycles, and it drops in the same cycle as the eighth falling edge.
- R7: A write presented while `busy`=1 is ignored. The byte in flight is sent unchanged, and no second byte starts after `busy` drops.
- R8: While `busy`=0, `cfg_clk` stays low and `cfg_dout` holds the last bit sent (the LSB of the last byte).
- R9: In external-clock mode (`sync_mode`=1), `cfg_clk` moves only on edges of `ext_clk`. If `ext_clk` is held still, `busy` stays high and no pulses appear. Eight `ext_clk` periods send one byte.
- R10: `in_ready` equals the inverse of `busy` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 selects the external clock, 0 selects the internal timer |
| ext_clk | input | 1 | External configuration clock, used in sync mode |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Configuration byte |
| busy | output | 1 | Byte is being shifted out |
| cfg_clk | output | 1 | Configuration clock burst, also exported to slaves |
| cfg_dout | output | 1 | Serial configuration data |

## Verification
The hardest condition to reach from the ports is a write that lands while a byte is in flight and is then silently dropped. A dropped write leaves no direct trace at the outputs. The bench therefore pulses `in_valid` with a different byte in the middle of a transfer and releases it before `busy` falls. It then confirms three things:
- The captured bits still spell the first byte.
- Exactly eight pulses were produced.
- `busy` stays low afterwards.

External-clock mode is reached by holding `ext_clk` still and confirming that the transfer stalls. The bench then toggles `ext_clk` by hand for eight periods.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  localparam int unsigned BYTE_W = 8;

  // clock-advance request fed to the shift core
  typedef struct packed {
    logic rise;
    logic fall;
  } step_t;
endpackage

// File: rtl/cfgser_osc.sv
module cfgser_osc #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfgser_extsync.sv
module cfgser_extsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/cfgser_shift.sv
module cfgser_shift
  import cfgser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  step_t             step,
  output logic              busy,
  output logic              sclk,
  output logic              sdout
);
  localparam int unsigned BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh;
  logic [BCW-1:0]    bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sclk  <= 1'b0;
      sdout <= 1'b0;
      sh    <= '0;
      bcnt  <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      sclk  <= 1'b0;
      sh    <= load_data;
      sdout <= load_data[BYTE_W-1];
      bcnt  <= '0;
    end else if (busy) begin
      if (!sclk && step.rise) begin
        sclk <= 1'b1;
      end else if (sclk && step.fall) begin
        sclk <= 1'b0;
        if (bcnt == LAST_BIT) begin
          busy <= 1'b0;
        end else begin
          sdout <= sh[BYTE_W-2];
          sh    <= sh << 1;
          bcnt  <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_byte_serializer.sv
module cfg_byte_serializer
  import cfgser_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              ext_clk,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              busy,
  output logic              cfg_clk,
  output logic              cfg_dout
);
  logic  accept;
  logic  tick;
  logic  ext_rise;
  logic  ext_fall;
  step_t step;

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;

  cfgser_osc #(.HALF_CYC(HALF_CYC)) u_osc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy & ~sync_mode),
    .tick    (tick)
  );

  cfgser_extsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_clk),
    .rise     (ext_rise),
    .fall     (ext_fall)
  );

  always_comb begin
    if (sync_mode) begin
      step.rise = ext_rise;
      step.fall = ext_fall;
    end else begin
      step.rise = tick;
      step.fall = tick;
    end
  end

  cfgser_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (in_data),
    .step      (step),
    .busy      (busy),
    .sclk      (cfg_clk),
    .sdout     (cfg_dout)
  );
endmodule

// File: rtl/cfgser_checker.sv
module cfgser_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic busy,
  input logic cfg_clk,
  input logic cfg_dout
);
  logic [3:0] rises;
  logic       clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises <= '0;
      clk_q <= 1'b0;
    end else begin
      clk_q <= cfg_clk;
      if (in_valid && in_ready) rises <= '0;
      else if (cfg_clk && !clk_q) rises <= rises + 1'b1;
    end
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  a_r2_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  a_r3_eight_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rises == 4'd8));

  a_r5_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_dout) |-> ($fell(cfg_clk) || $past(in_valid && in_ready)));

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_clk);
endmodule

bind cfg_byte_serializer cfgser_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .cfg_clk  (cfg_clk),
  .cfg_dout (cfg_dout)
);

// File: tb/tb_cfg_byte_serializer.sv
module tb_cfg_byte_serializer;
  localparam int H = 2;
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h3C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0;
  logic ext_clk = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, busy, cfg_clk, cfg_dout;

  int n_chk = 0;
  int n_bad = 0;
  int rises = 0;
  logic [7:0] cap = '0;
  logic prev_clk = 1'b0;

  always #10 clk = ~clk;

  cfg_byte_serializer #(.HALF_CYC(H)) dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ext_clk(ext_clk),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .busy(busy), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout));

  // capture bits at rising cfg_clk, sampled away from the active edge
  always @(negedge clk) begin
    if (cfg_clk && !prev_clk) begin
      rises <= rises + 1;
      cap   <= {cap[6:0], cfg_dout};
    end
    prev_clk <= cfg_clk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // waits for busy low; returns number of negedges busy was seen high
  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    int r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 ready", in_ready, 1);
    check("R1 clk", cfg_clk, 0);
    check("R1 dout", cfg_dout, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table-driven timer mode transfers
    for (int i = 0; i < NV; i++) begin
      r0 = rises;
      do_write(VEC[i]);
      check("R2 busy after write", busy, 1);
      check("R10 ready low", in_ready, 0);
      wait_idle(cyc);
      check("R6 busy cycles", cyc, 16 * H);
      check("R3 pulse count", rises - r0, 8);
      check("R4 msb-first bits", cap, VEC[i]);
      repeat (10) @(negedge clk);
      check("R8 idle dout holds lsb", cfg_dout, VEC[i][0]);
      check("R8 idle clk low", cfg_clk, 0);
      check("R10 ready high", in_ready, 1);
    end

    // R7 write during busy dropped
    r0 = rises;
    do_write(8'hC3);
    repeat (5) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h5A;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    wait_idle(cyc);
    check("R7 byte intact", cap, 8'hC3);
    check("R7 pulse count", rises - r0, 8);
    repeat (20) @(negedge clk);
    check("R7 not queued busy", busy, 0);
    check("R7 no extra pulses", rises - r0, 8);

    // R9 external clock mode
    sync_mode = 1'b1;
    r0 = rises;
    do_write(8'h96);
    repeat (40) @(negedge clk);
    check("R9 stalled busy", busy, 1);
    check("R9 stalled pulses", rises - r0, 0);
    for (int k = 0; k < 8; k++) begin
      ext_clk = 1'b1;
      repeat (6) @(negedge clk);
      ext_clk = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check("R9 busy done", busy, 0);
    check("R9 pulse count", rises - r0, 8);
    check("R9 bits", cap, 8'h96);
    check("R8 idle dout sync", cfg_dout, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule